// File: doc/BRIEF.md
# Serial-In Parallel-Out Output Expander

This block lets a controller drive a wide bank of output lines over four wires: a serial data bit, a clock, a strobe and an active-low clear. Each rising clock edge moves the serial bit into a shift register. Every clock edge that finds the strobe low copies the register into a holding latch, and the latch drives the parallel outputs. While the strobe is high, the controller can shift a new word in without disturbing the outputs. Lowering the strobe then publishes that word.

The last stage of the shift register is also a serial output. It can feed the data input of a further expander, so several devices can be chained into one long bit stream. The clear forces the latch and the outputs to zero. It leaves the shift register and the serial output alone.

The whole block is synchronous. The strobe acts as an enable on the latch register, sampled at the clock edge. The clear acts on the latch asynchronously.

Top module: `sipo_expander`

## Requirements
- R1: On every rising edge of `clk` the register shifts one place toward the top stage and takes `sdi` into stage 0, whatever `stb` and `clr_n` are doing.
- R2: At a rising edge where `stb` is high and `clr_n` is high, `pout` keeps its value.
- R3: At a rising edge where `stb` is low and `clr_n` is high, `pout` takes the shift register contents as they stood just before that edge.
- R4: If `stb` stays low over consecutive edges, `pout` changes at each of them. After each edge, `pout[WIDTH-1:1]` equals the previous `pout[WIDTH-2:0]`.
- R5: When `clr_n` goes low, `pout` becomes all zeros at once, without waiting for a clock edge, and stays zero while `clr_n` is low.
- R6: The clear does not change the shift register. A transfer made after the clear is released shows the bits that were shifted in before and during the clear.
- R7: `sdo` is the top stage of the shift register. Neither `stb` nor `clr_n` affects it.
- R8: The bit that enters first appears on `sdo` after `WIDTH` edges, and a transfer places it on `pout[WIDTH-1]`. Pin P20 is index 19 by default.
- R9: Two devices chained `sdo` to `sdi` with a shared clock and strobe behave as one 2×`WIDTH` shift chain. After 2×`WIDTH` bits and a transfer, the downstream device shows the first `WIDTH` bits sent and the upstream device shows the last `WIDTH`.
- R10: The clear has priority over the strobe. While `clr_n` is low, `pout` stays zero even at edges where `stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Active-low clear of the output latch, asynchronous |
| stb | input | 1 | Latch enable, low copies the shift register into the latch at a clock edge |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial output, top stage of the shift register |
| pout | output | WIDTH | Parallel outputs, index WIDTH-1 carries the oldest bit |

## Verification
The shift register has no reset, so the clocked properties assume the register has been flushed by at least one full word before the clear is first released. The bench shifts a full word of zeros while the clear is held low to meet that assumption. The properties also take `stb` and `sdi` to be stable around the rising edge. The bench therefore changes both only on the falling edge. It moves the clear only a little after the falling edge, which keeps every asynchronous clear well away from a shift edge.

// File: rtl/sipo_expander.sv
module sipo_expander #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             stb,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] pout
);
  localparam int TOP = WIDTH - 1;

  logic [TOP:0] shreg;
  logic [TOP:0] hold;

  always_ff @(posedge clk)
    shreg <= {shreg[TOP-1:0], sdi};

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)    hold <= '0;
    else if (!stb) hold <= shreg;

  assign sdo  = shreg[TOP];
  assign pout = hold;

  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    stb |=> pout == $past(pout));

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !stb |=> pout == $past(shreg));

  p_track_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (!stb && $past(!stb) && $past(clr_n)) |=> pout[TOP:1] == $past(pout[TOP-1:0]));

  p_sdo_top_r7: assert property (@(posedge clk) disable iff (!clr_n)
    !stb |=> pout[TOP] == $past(sdo));

  always @(negedge clk)
    if (!clr_n) p_clear_r5: assert (pout == '0);
endmodule

// File: tb/sipo_expander_test.sv
module sipo_expander_test;
  localparam int W = 20;
  localparam int PERIOD = 10;

  logic clk = 1'b0, clr_n = 1'b0, stb = 1'b1, sdi = 1'b0;
  logic sdo_u, sdo_d;
  logic [W-1:0] pout_u, pout_d;
  logic [W-1:0] su, sd, lu, ld;
  int vectors = 0, miscompares = 0;

  always #(PERIOD/2) clk = ~clk;

  sipo_expander #(.WIDTH(W)) uut (.clk(clk), .clr_n(clr_n), .stb(stb), .sdi(sdi), .sdo(sdo_u), .pout(pout_u));
  sipo_expander #(.WIDTH(W)) dn  (.clk(clk), .clr_n(clr_n), .stb(stb), .sdi(sdo_u), .sdo(sdo_d), .pout(pout_d));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    check({tag, " pout up"}, pout_u, lu);
    check({tag, " pout dn"}, pout_d, ld);
    check({tag, " sdo up"}, {{(W-1){1'b0}}, sdo_u}, {{(W-1){1'b0}}, su[W-1]});
    check({tag, " sdo dn"}, {{(W-1){1'b0}}, sdo_d}, {{(W-1){1'b0}}, sd[W-1]});
  endtask

  task automatic step(input logic d, input logic s, input bit chk, input string tag);
    sdi = d; stb = s;
    @(posedge clk);
    if (clr_n && !s) begin lu = su; ld = sd; end
    sd = {sd[W-2:0], su[W-1]};
    su = {su[W-2:0], d};
    @(negedge clk);
    if (chk) verify(tag);
  endtask

  task automatic set_clr(input logic v, input string tag);
    #2 clr_n = v;
    if (!v) begin lu = '0; ld = '0; end
    #1 verify(tag);
  endtask

  task automatic send_word(input logic [W-1:0] w, input logic s, input string tag);
    for (int i = W-1; i >= 0; i--) step(w[i], s, 1'b1, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c1, c2;
    a = 20'hA5C3E; b = 20'h3F01C; c1 = 20'h9E4B7; c2 = 20'h16D28;
    su = '0; sd = '0; lu = '0; ld = '0;
    @(negedge clk);
    for (int i = 0; i < 2*W; i++) step(1'b0, 1'b0, 1'b0, "flush");
    su = '0; sd = '0; lu = '0; ld = '0;
    verify("R5 reset state");
    #2 clr_n = 1'b1;
    @(negedge clk);

    send_word(a, 1'b1, "R1/R2 shift with strobe high");
    check("R8 first bit on sdo", {{(W-1){1'b0}}, sdo_u}, {{(W-1){1'b0}}, a[W-1]});
    step(1'b0, 1'b0, 1'b1, "R3 transfer");
    check("R3 pout equals word", pout_u, a);
    check("R8 first bit on top output", {{(W-1){1'b0}}, pout_u[W-1]}, {{(W-1){1'b0}}, a[W-1]});

    send_word(b, 1'b1, "R2 outputs held");
    for (int i = 0; i < 12; i++) step(1'(i % 3 == 0), 1'b0, 1'b1, "R4 outputs track shifts");

    set_clr(1'b0, "R5 asynchronous clear");
    for (int i = 0; i < 6; i++) step(1'(i & 1), 1'b0, 1'b1, "R10 clear beats strobe R7");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, "R7 sdo under clear");
    set_clr(1'b1, "R6 clear released");
    step(1'b0, 1'b0, 1'b1, "R6 register survived clear");

    send_word(c1, 1'b1, "R9 cascade first word");
    send_word(c2, 1'b1, "R9 cascade second word");
    step(1'b0, 1'b0, 1'b1, "R9 cascade transfer");
    check("R9 downstream holds first word", pout_d, c1);
    check("R9 upstream holds last word", pout_u, c2);
    step(1'b0, 1'b1, 1'b1, "R2 idle");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (i % 97 == 40) set_clr(1'b0, "R5 sweep clear");
      if (i % 97 == 55) set_clr(1'b1, "R6 sweep release");
      step(r[0], r[2] | r[3], 1'b1, "R1/R2/R3/R4/R7/R10 sweep");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule